// File: doc/BRIEF.md
# Operand Offset and Segment Generator

This block turns a decoded memory-operand descriptor into the two halves of a segmented address: a 16-bit offset within a segment and the 16-bit selector of the segment to use. The offset is the sum of any mix of a displacement, one base register and one index register. The segment comes from one of four segment registers: code, stack, data and extra. It follows the implicit rules for the kind of access unless a segment override prefix applies.

The caller presents the 2-bit `mod` and 3-bit `r/m` fields, the access kind, an optional override, the raw displacement and the current register values, with `inValid` high. One clock later the offset, the selector value and the selector identity appear with `validOut` high. Instruction fetches, stack pushes/pops and string destinations also pass through the offset adder. The caller frames their offset with the descriptor, for example as a direct displacement.

Top module: `opaddr_gen`

## Requirements
- R1: The offset is the 16-bit sum of the terms chosen by `r/m` (0: BX+SI, 1: BX+DI, 2: BP+SI, 3: BP+DI, 4: SI, 5: DI, 6: BP, 7: BX) plus the displacement term. Any carry beyond bit 15 is dropped.
- R2: With `mod`=01 the displacement term is `dispIn[7:0]` sign-extended to 16 bits. With `mod`=10 it is all of `dispIn`. With `mod`=00 it is zero, except for the R3 case.
- R3: With `mod`=00 and `r/m`=110 the offset is `dispIn` alone, with no base or index, and a data access defaults to the data segment.
- R4: A data access (`accessKind`=0) with no override uses the stack segment when BP is the base (`r/m` 2, 3, or 6 with `mod`≠00). Every other data access uses the data segment.
- R5: For a data access with `overrideEn`=1, the segment named by `overrideSeg` is used instead of the default.
- R6: An instruction fetch (`accessKind`=1) always uses the code segment, whatever the override inputs hold.
- R7: A stack push/pop (`accessKind`=2) always uses the stack segment, whatever the override inputs hold.
- R8: A string destination (`accessKind`=3) always uses the extra segment, whatever the override inputs hold.
- R9: An input is accepted when `inValid`=1 and `mod`≠11. `validOut` is high in exactly the cycle after an accepted input. Otherwise it is low and the offset and segment outputs keep their values.
- R10: While `rstN` is low, `validOut`, `offsetOut`, `segOut` and `segIdOut` are all zero.
- R11: `segIdOut` names the chosen segment with the encoding 0 extra, 1 code, 2 stack, 3 data, and `overrideSeg` uses that same encoding. `segOut` carries the value of that segment register as sampled with the accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Descriptor valid |
| modField | input | 2 | Addressing `mod` field |
| rmField | input | 3 | Addressing `r/m` field |
| accessKind | input | 2 | 0 data, 1 fetch, 2 stack push/pop, 3 string destination |
| overrideEn | input | 1 | Segment override prefix present |
| overrideSeg | input | 2 | Override segment id (R11 encoding) |
| dispIn | input | 16 | Raw displacement |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| segCs | input | 16 | Code segment selector |
| segSs | input | 16 | Stack segment selector |
| segDs | input | 16 | Data segment selector |
| segEs | input | 16 | Extra segment selector |
| validOut | output | 1 | Result valid |
| offsetOut | output | 16 | Effective offset |
| segOut | output | 16 | Selected segment selector value |
| segIdOut | output | 2 | Selected segment id |

## Verification
The only state is the output register and its valid flag. Any fault in decoding, in the adder or in the segment choice shows on the ports in the cycle right after the input that exposes it. A wrong hold or a wrong acceptance decision shows as a `validOut` that differs from the model, or as outputs that move with no accepted input. Both appear within one clock. The bench covers every `r/m` and `mod` combination, negative short displacements, sums that wrap, and overrides that are offered to fixed-segment accesses. This exposes each such fault within a few cycles of the input that provokes it.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } segId_e;

  typedef enum logic [1:0] {
    ACC_DATA   = 2'd0,
    ACC_FETCH  = 2'd1,
    ACC_STACK  = 2'd2,
    ACC_STRDST = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_SHORT = 2'd1,
    DISP_FULL  = 2'd2
  } dispSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     useBase;
    logic     baseIsBp;
    logic     useIndex;
    logic     indexIsDi;
    dispSel_e dispSel;
    segId_e   segSel;
  } eagCtrl_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] modField,
  input  logic [2:0] rmField,
  input  logic [1:0] accessKind,
  input  logic       overrideEn,
  input  logic [1:0] overrideSeg,
  output eagCtrl_t   ctrl
);
  logic isDirect;
  logic memOp;
  logic bpBase;

  always_comb begin
    isDirect = (modField == 2'b00) && (rmField == 3'b110);
    memOp    = (modField != 2'b11);

    ctrl.load      = inValid && memOp;
    ctrl.useBase   = (rmField[2] == 1'b0) || (rmField == 3'b111) ||
                     ((rmField == 3'b110) && !isDirect);
    ctrl.baseIsBp  = (rmField == 3'b010) || (rmField == 3'b011) || (rmField == 3'b110);
    ctrl.useIndex  = (rmField[2] == 1'b0) || (rmField[2:1] == 2'b10);
    ctrl.indexIsDi = rmField[0];

    unique case (modField)
      2'b01:   ctrl.dispSel = DISP_SHORT;
      2'b10:   ctrl.dispSel = DISP_FULL;
      2'b00:   ctrl.dispSel = isDirect ? DISP_FULL : DISP_NONE;
      default: ctrl.dispSel = DISP_NONE;
    endcase

    bpBase = ctrl.useBase && ctrl.baseIsBp;

    unique case (access_e'(accessKind))
      ACC_FETCH:  ctrl.segSel = SEG_CS;
      ACC_STACK:  ctrl.segSel = SEG_SS;
      ACC_STRDST: ctrl.segSel = SEG_ES;
      default:    ctrl.segSel = overrideEn ? segId_e'(overrideSeg)
                                           : (bpBase ? SEG_SS : SEG_DS);
    endcase
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DISP_SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  eagCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] dispIn,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  input  logic [ADDR_W-1:0] segCs,
  input  logic [ADDR_W-1:0] segSs,
  input  logic [ADDR_W-1:0] segDs,
  input  logic [ADDR_W-1:0] segEs,
  output logic              validOut,
  output logic [ADDR_W-1:0] offsetOut,
  output logic [ADDR_W-1:0] segOut,
  output logic [1:0]        segIdOut
);
  localparam int EXT_W = ADDR_W - DISP_SHORT_W;

  logic [ADDR_W-1:0] dispTerm;
  logic [ADDR_W-1:0] baseTerm;
  logic [ADDR_W-1:0] indexTerm;
  logic [ADDR_W-1:0] offsetSum;
  logic [ADDR_W-1:0] segValue;

  always_comb begin
    unique case (ctrl.dispSel)
      DISP_SHORT: dispTerm = {{EXT_W{dispIn[DISP_SHORT_W-1]}}, dispIn[DISP_SHORT_W-1:0]};
      DISP_FULL:  dispTerm = dispIn;
      default:    dispTerm = '0;
    endcase
    baseTerm  = ctrl.useBase  ? (ctrl.baseIsBp  ? regBp : regBx) : '0;
    indexTerm = ctrl.useIndex ? (ctrl.indexIsDi ? regDi : regSi) : '0;
    offsetSum = dispTerm + baseTerm + indexTerm;  // wraps at ADDR_W bits

    unique case (ctrl.segSel)
      SEG_ES:  segValue = segEs;
      SEG_CS:  segValue = segCs;
      SEG_SS:  segValue = segSs;
      default: segValue = segDs;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      offsetOut <= '0;
      segOut    <= '0;
      segIdOut  <= '0;
    end else begin
      validOut <= ctrl.load;
      if (ctrl.load) begin
        offsetOut <= offsetSum;
        segOut    <= segValue;
        segIdOut  <= ctrl.segSel;
      end
    end
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DISP_SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        modField,
  input  logic [2:0]        rmField,
  input  logic [1:0]        accessKind,
  input  logic              overrideEn,
  input  logic [1:0]        overrideSeg,
  input  logic [ADDR_W-1:0] dispIn,
  input  logic [ADDR_W-1:0] regBx,
  input  logic [ADDR_W-1:0] regBp,
  input  logic [ADDR_W-1:0] regSi,
  input  logic [ADDR_W-1:0] regDi,
  input  logic [ADDR_W-1:0] segCs,
  input  logic [ADDR_W-1:0] segSs,
  input  logic [ADDR_W-1:0] segDs,
  input  logic [ADDR_W-1:0] segEs,
  output logic              validOut,
  output logic [ADDR_W-1:0] offsetOut,
  output logic [ADDR_W-1:0] segOut,
  output logic [1:0]        segIdOut
);
  eagCtrl_t ctrl;

  eag_ctrl i_ctrl (
    .inValid    (inValid),
    .modField   (modField),
    .rmField    (rmField),
    .accessKind (accessKind),
    .overrideEn (overrideEn),
    .overrideSeg(overrideSeg),
    .ctrl       (ctrl)
  );

  eag_datapath #(
    .ADDR_W      (ADDR_W),
    .DISP_SHORT_W(DISP_SHORT_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .dispIn   (dispIn),
    .regBx    (regBx),
    .regBp    (regBp),
    .regSi    (regSi),
    .regDi    (regDi),
    .segCs    (segCs),
    .segSs    (segSs),
    .segDs    (segDs),
    .segEs    (segEs),
    .validOut (validOut),
    .offsetOut(offsetOut),
    .segOut   (segOut),
    .segIdOut (segIdOut)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        modField,
  input logic [1:0]        accessKind,
  input logic              overrideEn,
  input logic [1:0]        overrideSeg,
  input logic [ADDR_W-1:0] segCs,
  input logic [ADDR_W-1:0] segSs,
  input logic [ADDR_W-1:0] segEs,
  input logic              validOut,
  input logic [ADDR_W-1:0] offsetOut,
  input logic [ADDR_W-1:0] segOut,
  input logic [1:0]        segIdOut
);
  logic pastOk;
  always_ff @(posedge clk) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (!validOut && offsetOut == '0 && segIdOut == 2'd0); // R10
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    validOut == $past(inValid && modField != 2'b11)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    !validOut |-> ($stable(offsetOut) && $stable(segOut) && $stable(segIdOut))); // R9

  AST_FETCH_CS: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (validOut && $past(accessKind) == 2'd1) |-> (segIdOut == 2'd1 && segOut == $past(segCs))); // R6

  AST_STACK_SS: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (validOut && $past(accessKind) == 2'd2) |-> (segIdOut == 2'd2 && segOut == $past(segSs))); // R7

  AST_STRDST_ES: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (validOut && $past(accessKind) == 2'd3) |-> (segIdOut == 2'd0 && segOut == $past(segEs))); // R8

  AST_OVERRIDE_USED: assert property (@(posedge clk) disable iff (!rstN || !pastOk)
    (validOut && $past(accessKind) == 2'd0 && $past(overrideEn)) |-> segIdOut == $past(overrideSeg)); // R5
endmodule

bind opaddr_gen eag_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_opaddr_gen.sv
`timescale 1ns/1ps
module test_opaddr_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  modField = '0;
  logic [2:0]  rmField = '0;
  logic [1:0]  accessKind = '0;
  logic        overrideEn = 1'b0;
  logic [1:0]  overrideSeg = '0;
  logic [15:0] dispIn = '0, regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic [15:0] segCs = 16'h1111, segSs = 16'h2222, segDs = 16'h3333, segEs = 16'h4444;
  logic        validOut;
  logic [15:0] offsetOut, segOut;
  logic [1:0]  segIdOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  opaddr_gen i_opaddr_gen (.*);

  // behavioural reference
  function automatic int refOffset(int md, int rm, int d, int bx, int bp, int si, int di);
    int sum = 0;
    if (md == 0 && rm == 6) return d;
    case (rm)
      0: sum = bx + si;  1: sum = bx + di;
      2: sum = bp + si;  3: sum = bp + di;
      4: sum = si;       5: sum = di;
      6: sum = bp;       default: sum = bx;
    endcase
    if (md == 1) sum += ((d & 255) >= 128) ? (d & 255) - 256 : (d & 255);
    if (md == 2) sum += d;
    return sum & 16'hFFFF;
  endfunction

  function automatic int refSegId(int kind, int md, int rm, bit ov, int ovSeg);
    bit viaBp;
    if (kind == 1) return 1;
    if (kind == 2) return 2;
    if (kind == 3) return 0;
    if (ov) return ovSeg;
    viaBp = (rm == 2 || rm == 3 || (rm == 6 && md != 0));
    return viaBp ? 2 : 3;
  endfunction

  bit          expValid = 0;
  int          expOff = 0, expSegId = 0, expSegVal = 0;
  string       expTag = "R9";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid = 0;
      expOff = 0; expSegId = 0; expSegVal = 0;
    end else begin
      expValid = inValid && modField != 2'd3;
      if (expValid) begin
        expOff   = refOffset(modField, rmField, dispIn, regBx, regBp, regSi, regDi);
        expSegId = refSegId(accessKind, modField, rmField, overrideEn, overrideSeg);
        case (expSegId)
          0: expSegVal = segEs; 1: expSegVal = segCs;
          2: expSegVal = segSs; default: expSegVal = segDs;
        endcase
        expTag = curTag;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        check("R10", {validOut, offsetOut, segOut, segIdOut}, 0);
      end else begin
        check("R9", validOut, expValid);
        check("R9", offsetOut, expOff);        // also holds when idle
        check(expTag, segOut, expSegVal);
        check((expTag == "R1") ? "R11" : expTag, segIdOut, expSegId);
      end
    end
  end

  task automatic put(string tag, bit v, int md, int rm, int kind, bit ov, int ovs, int d);
    @(negedge clk);
    curTag = tag; inValid = v; modField = md[1:0]; rmField = rm[2:0];
    accessKind = kind[1:0]; overrideEn = ov; overrideSeg = ovs[1:0]; dispIn = d[15:0];
  endtask

  task automatic finish();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    regBx = 16'h0100; regBp = 16'h0200; regSi = 16'h0030; regDi = 16'h0004;
    // R1: every r/m with full displacement
    for (int rm = 0; rm < 8; rm++) put("R1", 1, 2, rm, 0, 0, 0, 16'h1000);
    // R2: short negative and positive displacement, mod 00 ignores disp
    put("R2", 1, 1, 7, 0, 0, 0, 16'hABF0);
    put("R2", 1, 1, 4, 0, 0, 0, 16'hFF7F);
    put("R2", 1, 0, 0, 0, 0, 0, 16'h5555);
    put("R2", 1, 0, 7, 0, 0, 0, 16'h5555);
    // R3: direct addressing
    put("R3", 1, 0, 6, 0, 0, 0, 16'hBEEF);
    // R1: wrap of the sum
    regBx = 16'hFFF0; regSi = 16'h0020;
    put("R1", 1, 2, 0, 0, 0, 0, 16'h8000);
    // R4: BP base goes to stack, others to data
    put("R4", 1, 1, 2, 0, 0, 0, 16'h0001);
    put("R4", 1, 2, 6, 0, 0, 0, 16'h0002);
    put("R4", 1, 0, 3, 0, 0, 0, 0);
    put("R4", 1, 0, 5, 0, 0, 0, 0);
    // R5: override on data refs, including BP base
    for (int s = 0; s < 4; s++) put("R5", 1, 1, 2, 0, 1, s, 16'h0010);
    // R6-R8: fixed segments ignore override
    put("R6", 1, 0, 6, 1, 1, 3, 16'h0123);
    put("R6", 1, 1, 3, 1, 1, 2, 16'h0001);
    put("R7", 1, 2, 7, 2, 1, 0, 16'h0002);
    put("R7", 1, 0, 4, 2, 1, 3, 0);
    put("R8", 1, 0, 5, 3, 1, 1, 0);
    put("R8", 1, 1, 2, 3, 1, 2, 16'h0080);
    // R9: mod 11 and idle cycles change nothing
    put("R9", 1, 3, 1, 0, 0, 0, 16'h7777);
    put("R9", 0, 2, 1, 0, 0, 0, 16'h7777);
    put("R9", 1, 2, 1, 0, 0, 0, 16'h0042);
    put("R9", 0, 0, 0, 0, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 400; i++) begin
      regBx = 16'($urandom); regBp = 16'($urandom);
      regSi = 16'($urandom); regDi = 16'($urandom);
      segCs = 16'($urandom); segSs = 16'($urandom);
      segDs = 16'($urandom); segEs = 16'($urandom);
      put("R1", ($urandom % 4) != 0, $urandom % 4, $urandom % 8, $urandom % 4,
          $urandom % 2, $urandom % 4, $urandom);
    end
    put("R9", 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finish();
  end
endmodule